// File: doc/BRIEF.md
# Audio De-Emphasis Shelving Filter

This block applies the standard audio de-emphasis response to one channel of signed PCM samples. The response is a first-order shelf formed by a 50 µs pole and a 15 µs zero, with corners near 3.183 kHz and 10.61 kHz. It has 0 dB gain at low frequency and falls toward about -10 dB at high frequency. The shape scales with the sample rate, so a separate coefficient set is kept for each of 32 kHz, 44.1 kHz and 48 kHz. The coefficients come from a bilinear transform of the analogue prototype.

A 2-bit rate select picks one coefficient set or bypass. A 2-bit speed-mode input forces bypass whenever the stream is not single-speed. Each accepted input sample yields exactly one output sample one clock later. The filter keeps one input and one output sample of history. That history is cleared on reset, on any change of the rate select, and while the filter is bypassed.

Top module: `deemph_filter`

## Requirements
- R1: While rst_ni is low, valid_o and y_o are held at zero.
- R2: valid_o is high in exactly the cycles that follow a cycle with valid_i high. While valid_o is low, y_o holds its last value.
- R3: Rate select encoding is 00 bypass, 01 44.1 kHz, 10 48 kHz, 11 32 kHz. With select 00, y_o equals the x_i accepted one cycle earlier.
- R4: Speed-mode encoding is 00 single, 01 double, 10 quad, 11 reserved. In any mode other than 00, y_o equals the accepted x_i, whatever the rate select.
- R5: When the filter is active, y = sat((b0*x + b1*xp - a1*yp + 2^21) >>> 22). Here xp is the previous accepted input and yp is the previous output, both zero when the history is clear.
- R6: Coefficients in Q2.22 as (b0, b1, a1) are: 44.1 kHz (1800993, -250417, -2643728), 48 kHz (1764502, -318188, -2747990), 32 kHz (1957342, 39946, -2197016).
- R7: The result is saturated to the signed DW-bit range. A held full-scale input of either sign never produces an output of the opposite sign.
- R8: A change of rate select clears the history. The first sample taken with the new select uses xp = yp = 0.
- R9: Any cycle in bypass clears the history. The first filtered sample after bypass uses xp = yp = 0.
- R10: Unity gain at DC: a held constant input settles to within 2 LSB of that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| x_i | input | DW | Signed input sample |
| rate_sel_i | input | 2 | Rate / bypass select |
| spd_mode_i | input | 2 | Stream speed mode |
| valid_o | output | 1 | Output sample strobe |
| y_o | output | DW | Signed output sample |

## Verification
The assertions check on every cycle the parts of the behaviour that need no arithmetic: the idle reset state, the one-cycle strobe relation, holding of y_o between samples, and exact pass-through under either bypass condition. The filter arithmetic needs the bench's fixed-point model, which is kept sample by sample. So do the clearing of history on a select change or after bypass, saturation at full scale, and settling to unity gain at DC. These are shown only through directed and random sample sequences.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  localparam int CW   = 24;  // Q2.22
  localparam int FRAC = 22;

  typedef logic signed [CW-1:0] coef_t;

  typedef struct packed {
    coef_t b0;
    coef_t b1;
    coef_t a1;
  } coef_set_t;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_44K1 = 2'b01,
    SEL_48K  = 2'b10,
    SEL_32K  = 2'b11
  } rate_sel_e;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } spd_mode_e;
endpackage

// File: rtl/deemph_coef.sv
module deemph_coef
  import deemph_pkg::*;
(
  input  logic [1:0] sel_i,
  output coef_set_t  coef_o
);
  always_comb begin
    case (sel_i)
      SEL_44K1: coef_o = '{b0: 24'sd1800993, b1: -24'sd250417, a1: -24'sd2643728};
      SEL_48K:  coef_o = '{b0: 24'sd1764502, b1: -24'sd318188, a1: -24'sd2747990};
      SEL_32K:  coef_o = '{b0: 24'sd1957342, b1: 24'sd39946,   a1: -24'sd2197016};
      default:  coef_o = '{b0: 24'sd4194304, b1: 24'sd0,       a1: 24'sd0};
    endcase
  end
endmodule

// File: rtl/deemph_mac.sv
module deemph_mac
  import deemph_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] xp_i,
  input  logic signed [DW-1:0] yp_i,
  input  coef_set_t            coef_i,
  output logic signed [DW-1:0] y_o
);
  localparam int AW = DW + CW + 2;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] YMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  coef_t b0, b1, a1;
  logic signed [AW-1:0] acc, rnd, shr;

  always_comb begin
    b0  = coef_i.b0;
    b1  = coef_i.b1;
    a1  = coef_i.a1;
    acc = AW'(x_i) * AW'(b0) + AW'(xp_i) * AW'(b1) - AW'(yp_i) * AW'(a1);
    rnd = acc + HALF;
    shr = rnd >>> FRAC;
    if (shr > YMAX)      y_o = YMAX[DW-1:0];
    else if (shr < YMIN) y_o = YMIN[DW-1:0];
    else                 y_o = shr[DW-1:0];
  end
endmodule

// File: rtl/deemph_filter.sv
module deemph_filter
  import deemph_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] x_i,
  input  logic [1:0]           rate_sel_i,
  input  logic [1:0]           spd_mode_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] y_o
);
  logic [1:0]           sel_q;
  logic signed [DW-1:0] x_hist, y_hist, xp_eff, yp_eff, y_flt, y_next;
  logic                 sel_chg, bypass;
  coef_set_t            coef;

  assign sel_chg = (rate_sel_i != sel_q);
  assign bypass  = (rate_sel_i == SEL_OFF) || (spd_mode_i != SPD_SINGLE);
  assign xp_eff  = sel_chg ? '0 : x_hist;
  assign yp_eff  = sel_chg ? '0 : y_hist;

  deemph_coef u_coef (
    .sel_i  (rate_sel_i),
    .coef_o (coef)
  );

  deemph_mac #(.DW(DW)) u_mac (
    .x_i    (x_i),
    .xp_i   (xp_eff),
    .yp_i   (yp_eff),
    .coef_i (coef),
    .y_o    (y_flt)
  );

  assign y_next = bypass ? x_i : y_flt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= SEL_OFF;
      x_hist  <= '0;
      y_hist  <= '0;
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      sel_q   <= rate_sel_i;
      valid_o <= valid_i;
      if (valid_i) y_o <= y_next;
      if (bypass) begin
        x_hist <= '0;
        y_hist <= '0;
      end else if (valid_i) begin
        x_hist <= x_i;
        y_hist <= y_flt;
      end else if (sel_chg) begin
        x_hist <= '0;
        y_hist <= '0;
      end
    end
  end
endmodule

// File: rtl/deemph_filter_chk.sv
module deemph_filter_chk #(
  parameter int DW = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic signed [DW-1:0] x_i,
  input logic [1:0]           rate_sel_i,
  input logic [1:0]           spd_mode_i,
  input logic                 valid_o,
  input logic signed [DW-1:0] y_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_rst_idle_r1: assert (valid_o == 1'b0 && y_o == '0);
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(y_o)));

  p_sel_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rate_sel_i == 2'b00) |=> (y_o == $past(x_i)));

  p_mode_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && spd_mode_i != 2'b00) |=> (y_o == $past(x_i)));
endmodule

bind deemph_filter deemph_filter_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .x_i        (x_i),
  .rate_sel_i (rate_sel_i),
  .spd_mode_i (spd_mode_i),
  .valid_o    (valid_o),
  .y_o        (y_o)
);

// File: tb/deemph_filter_bench.sv
module deemph_filter_bench;
  localparam int DW = 24;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 valid_i = 1'b0;
  logic signed [DW-1:0] x_i = '0;
  logic [1:0]           rate_sel_i = 2'b00;
  logic [1:0]           spd_mode_i = 2'b00;
  logic                 valid_o;
  logic signed [DW-1:0] y_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R1";

  longint mxp, myp, exp_y;
  bit     exp_v, chk_on;
  logic [1:0] msel;

  always #2 clk = ~clk;

  deemph_filter #(.DW(DW)) u_deemph_filter (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .rate_sel_i(rate_sel_i), .spd_mode_i(spd_mode_i),
    .valid_o(valid_o), .y_o(y_o)
  );

  function automatic longint sat(input longint v);
    longint hi = (64'sd1 <<< (DW-1)) - 1;
    longint lo = -(64'sd1 <<< (DW-1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // R6 coefficient values, R5 recurrence
  function automatic longint filt(input longint x, input longint xp, input longint yp,
                                  input logic [1:0] s);
    longint b0, b1, a1, acc;
    case (s)
      2'b01:   begin b0 = 1800993; b1 = -250417; a1 = -2643728; end
      2'b10:   begin b0 = 1764502; b1 = -318188; a1 = -2747990; end
      default: begin b0 = 1957342; b1 = 39946;   a1 = -2197016; end
    endcase
    acc = b0*x + b1*xp - a1*yp + (64'sd1 <<< 21);
    return sat(acc >>> 22);
  endfunction

  task automatic check_out();
    checks++;
    if (valid_o !== exp_v || longint'(y_o) != exp_y) begin
      errors++;
      $display("FAIL %s: valid_o=%0b y_o=%0d expected valid=%0b y=%0d",
               tag, valid_o, y_o, exp_v, exp_y);
    end
  endtask

  task automatic step(input bit v, input longint x, input logic [1:0] s, input logic [1:0] m);
    bit clr, byp;
    longint hx, hy, y;
    @(negedge clk);
    if (chk_on) check_out();
    valid_i = v; x_i = DW'(x); rate_sel_i = s; spd_mode_i = m;
    clr = (s != msel); msel = s;
    byp = (s == 2'b00) || (m != 2'b00);
    hx = clr ? 0 : mxp; hy = clr ? 0 : myp;
    y = byp ? x : filt(x, hx, hy, s);
    if (byp) begin mxp = 0; myp = 0; end
    else if (v) begin mxp = x; myp = y; end
    else if (clr) begin mxp = 0; myp = 0; end
    exp_v = v;
    if (v) exp_y = y;
    chk_on = 1;
  endtask

  function automatic longint rnd_x();
    logic signed [DW-1:0] r = DW'($urandom);
    return longint'(r);
  endfunction

  initial begin
    void'($urandom(32'd5150));
    mxp = 0; myp = 0; exp_y = 0; exp_v = 0; chk_on = 0; msel = 2'b00;
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (valid_o !== 1'b0 || y_o !== '0) begin
      errors++;
      $display("FAIL R1: valid_o=%0b y_o=%0d expected 0 0", valid_o, y_o);
    end
    rst_ni = 1'b1;
    chk_on = 1;

    tag = "R3";
    for (int i = 0; i < 30; i++) step($urandom_range(0,1), rnd_x(), 2'b00, 2'b00);
    tag = "R4";
    for (int i = 0; i < 40; i++)
      step($urandom_range(0,1), rnd_x(), 2'($urandom_range(1,3)), 2'($urandom_range(1,3)));
    tag = "R5 R6";
    for (int s = 1; s < 4; s++)
      for (int i = 0; i < 150; i++) step($urandom_range(0,3) != 0, rnd_x(), 2'(s), 2'b00);
    tag = "R2";
    for (int i = 0; i < 40; i++) step(i[0], rnd_x(), 2'b01, 2'b00);
    tag = "R8";
    for (int i = 0; i < 60; i++) step(1'b1, rnd_x(), 2'((i / 5) % 3 + 1), 2'b00);
    tag = "R9";
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 6; i++) step(1'b1, rnd_x(), 2'b10, 2'b00);
      step(1'b0, 0, 2'b10, 2'(k % 3 + 1));
      for (int i = 0; i < 3; i++) step(1'b1, rnd_x(), 2'b10, 2'b00);
    end

    tag = "R7";
    for (int s = 1; s < 4; s++) begin
      for (int i = 0; i < 200; i++) step(1'b1, (64'sd1 <<< (DW-1)) - 1, 2'(s), 2'b00);
      @(negedge clk); check_out();
      checks++;
      if (y_o < 0) begin errors++; $display("FAIL R7: y_o=%0d expected positive", y_o); end
      for (int i = 0; i < 200; i++) step(1'b1, -(64'sd1 <<< (DW-1)), 2'(s), 2'b00);
      @(negedge clk); check_out();
      checks++;
      if (y_o >= 0) begin errors++; $display("FAIL R7: y_o=%0d expected negative", y_o); end
    end

    tag = "R10";
    for (int i = 0; i < 300; i++) step(1'b1, 1000000, 2'b10, 2'b00);
    @(negedge clk); check_out();
    checks++;
    if (longint'(y_o) > 1000002 || longint'(y_o) < 999998) begin
      errors++; $display("FAIL R10: y_o=%0d expected 1000000 +-2", y_o);
    end

    tag = "R5";
    begin
      logic [1:0] s = 2'b01;
      logic [1:0] m = 2'b00;
      for (int i = 0; i < 2000; i++) begin
        if ($urandom_range(0,19) == 0) s = 2'($urandom);
        if ($urandom_range(0,29) == 0) m = ($urandom_range(0,3) == 0) ? 2'($urandom) : 2'b00;
        step($urandom_range(0,3) != 0, rnd_x(), s, m);
      end
    end
    @(negedge clk); check_out();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule